// File: doc/BRIEF.md
# Qualified Windowed Capture Buffer

This block records a data bus into on-chip storage so that a host can unload it later, in the manner of an embedded logic analyser. The storage is divided into a selectable number of equal windows. Each accepted trigger opens the next window, and that window fills with samples before the block waits for another trigger. Successive triggers therefore land in successive windows, and a slow, sparse signal can be captured once per event without one event's samples filling the whole store.

An optional storage qualifier narrows which clocks are recorded. When it is enabled, a clock in an open window stores a sample only if the qualifier input is high, so a single-cycle strobe stores exactly one sample. For each window the block also keeps a stamp: the number of clocks between arming and the trigger that opened that window.

A capture starts with an arm pulse and ends when the last window is full. The done flag then rises and the store is frozen. While the block is not armed, the host reads samples and stamps through registered address/data ports.

Top module: `qcap_buffer`

## Requirements
- R1: After reset, `armed` and `done` are low and both read data outputs are zero. An `arm` pulse starts a new capture in any state, whatever is in progress. From the next edge `armed` is high and `done` is low. While `arm` is high, `trig` has no effect.
- R2: The window count is 2 to the power of `win_log2`, latched at arm. A value above log2(DEPTH) is treated as log2(DEPTH). Each window holds DEPTH divided by the window count.
- R3: While the block is armed and no window is open, a high `trig` opens the next window. Windows fill in order of their index, and window k occupies addresses k*size to k*size+size-1. The clock on which the trigger is accepted is itself a sampling clock.
- R4: With `qual_en` low at arm, every clock of an open window stores `din`, until that window is full.
- R5: With `qual_en` high at arm, a clock of an open window stores `din` only when `qual` is high. Clocks with `qual` low store nothing and do not advance the fill.
- R6: A `trig` that arrives while a window is still filling is ignored. It neither opens a window nor records a stamp.
- R7: `done` rises, and `armed` falls, on the edge that stores the final sample of the last window. After that, `trig`, `qual` and `din` change nothing in the store until the next arm.
- R8: While not armed, `rd_data` shows the sample at `rd_addr` one edge after the address is applied. On any edge where the block is armed, `rd_data` becomes zero.
- R9: The stamp of a window is the count of armed clocks before the trigger that opened it. The first clock after the arm edge counts as 0, and the count saturates at its maximum. `ts_data` shows the stamp of window `ts_idx` one edge later while not armed, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture |
| win_log2 | input | $clog2($clog2(DEPTH)+1) | log2 of window count, latched at arm |
| qual_en | input | 1 | Enable storage qualification, latched at arm |
| trig | input | 1 | Trigger event |
| qual | input | 1 | Storage qualifier |
| din | input | DATA_W | Sampled data bus |
| rd_addr | input | $clog2(DEPTH) | Sample read address |
| rd_data | output | DATA_W | Sample read data, one-cycle latency |
| ts_idx | input | $clog2(DEPTH) | Stamp read window index |
| ts_data | output | TS_W | Stamp read data, one-cycle latency |
| armed | output | 1 | Capture in progress |
| done | output | 1 | Last window full, store frozen |

## Verification
The inputs a clock presents act on the edge that ends that clock. `armed` and `done` therefore change on that same edge, and so does the store: a sample or stamp captured there can be read back through the ports starting with the address applied after it. The read outputs follow their address or window index after one edge. The bench drives its inputs and samples all outputs one time unit after each rising edge, so every value it reads reflects exactly the edge just past. A read-data check is made only when the block was already unarmed at the previous edge. The expected store, stamps and flags come from an arithmetic model that the bench updates one clock at a time from the stimulus it drives. Sweeps cover every window count, including a clamped setting, with qualification both off and on.

// File: rtl/qcap_pkg.sv
package qcap_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_WAIT = 2'd1,
      S_FILL = 2'd2,
      S_DONE = 2'd3
   } qcap_state_e;
endpackage

// File: rtl/qcap_ctrl.sv
module qcap_ctrl
   import qcap_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int TS_W      = 8,
   parameter bit SAT_STAMP = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(AW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic [LW-1:0]   win_log2,
   input  logic            qual_en,
   input  logic            trig,
   input  logic            qual,
   output logic            we,
   output logic [AW-1:0]   waddr,
   output logic            stamp_we,
   output logic [AW-1:0]   stamp_idx,
   output logic [TS_W-1:0] stamp_val,
   output logic            armed,
   output logic            done
);
   qcap_state_e     state;
   logic [AW-1:0]   wptr;
   logic [TS_W-1:0] cyc, cyc_nxt;
   logic [LW-1:0]   wl_q, wl_in, shamt;
   logic            qen_q;
   logic [AW-1:0]   wmask;
   logic            accept, open_win, last_in_win, last_all;

   assign wl_in       = (win_log2 > LW'(AW)) ? LW'(AW) : win_log2;
   assign shamt       = LW'(AW) - wl_q;
   assign wmask       = AW'(DEPTH - 1) >> wl_q;
   assign accept      = !arm && (state == S_WAIT) && trig;
   assign open_win    = (state == S_FILL) || accept;
   assign we          = !arm && open_win && (!qen_q || qual);
   assign last_in_win = (wptr & wmask) == wmask;
   assign last_all    = wptr == AW'(DEPTH - 1);

   assign waddr     = wptr;
   assign stamp_we  = accept;
   assign stamp_idx = wptr >> shamt;
   assign stamp_val = cyc;
   assign armed     = (state == S_WAIT) || (state == S_FILL);
   assign done      = state == S_DONE;

   generate
      if (SAT_STAMP) begin : g_sat
         assign cyc_nxt = (&cyc) ? cyc : cyc + 1'b1;
      end else begin : g_wrap
         assign cyc_nxt = cyc + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         wptr  <= '0;
         cyc   <= '0;
         wl_q  <= '0;
         qen_q <= 1'b0;
      end else if (arm) begin
         state <= S_WAIT;
         wptr  <= '0;
         cyc   <= '0;
         wl_q  <= wl_in;
         qen_q <= qual_en;
      end else if (armed) begin
         cyc <= cyc_nxt;
         if (we) wptr <= wptr + 1'b1;
         if (we && last_in_win) state <= last_all ? S_DONE : S_WAIT;
         else if (accept)       state <= S_FILL;
      end
   end

   a_r5_qual_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (we && qen_q) |-> qual);
   a_r3_window_start: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ((wptr & wmask) == '0));
   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(we) && $past(wptr) == AW'(DEPTH - 1)));
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> $stable(wptr));
   a_r6_fill_no_stamp: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FILL) |-> !stamp_we);
endmodule

// File: rtl/qcap_store.sv
module qcap_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[raddr];
      else            rdata <= '0;
   end

   a_r8_blank_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));
endmodule

// File: rtl/qcap_stamps.sv
module qcap_stamps #(
   parameter int DEPTH = 16,
   parameter int TS_W  = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   widx,
   input  logic [TS_W-1:0] wval,
   input  logic            rd_en,
   input  logic [AW-1:0]   ridx,
   output logic [TS_W-1:0] rdata
);
   logic [TS_W-1:0] slot [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (we) begin
         slot[widx] <= wval;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= slot[ridx];
      else            rdata <= '0;
   end

   a_r9_blank_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));
endmodule

// File: rtl/qcap_buffer.sv
module qcap_buffer #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int TS_W      = 8,
   parameter bit SAT_STAMP = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(AW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [LW-1:0]     win_log2,
   input  logic              qual_en,
   input  logic              trig,
   input  logic              qual,
   input  logic [DATA_W-1:0] din,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [AW-1:0]     ts_idx,
   output logic [TS_W-1:0]   ts_data,
   output logic              armed,
   output logic              done
);
   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("qcap_buffer: DEPTH must be a power of two of at least 16");
      end
      if (DATA_W < 1 || TS_W < 1) begin : g_bad_width
         $error("qcap_buffer: DATA_W and TS_W must be positive");
      end
   endgenerate

   logic            we, stamp_we;
   logic [AW-1:0]   waddr, stamp_idx;
   logic [TS_W-1:0] stamp_val;

   qcap_ctrl #(.DEPTH(DEPTH), .TS_W(TS_W), .SAT_STAMP(SAT_STAMP)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .win_log2(win_log2),
      .qual_en(qual_en), .trig(trig), .qual(qual),
      .we(we), .waddr(waddr),
      .stamp_we(stamp_we), .stamp_idx(stamp_idx), .stamp_val(stamp_val),
      .armed(armed), .done(done)
   );

   qcap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(din),
      .rd_en(!armed), .raddr(rd_addr), .rdata(rd_data)
   );

   qcap_stamps #(.DEPTH(DEPTH), .TS_W(TS_W)) stamps_i (
      .clk(clk), .rst_n(rst_n), .we(stamp_we), .widx(stamp_idx),
      .wval(stamp_val), .rd_en(!armed), .ridx(ts_idx), .rdata(ts_data)
   );

   a_r1_armed_xor_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed && done));
   a_r1_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (armed && !done));
endmodule

// File: tb/qcap_buffer_tb.sv
module qcap_buffer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8, DEPTH = 16, TSW = 8, AW = 4, LW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic arm = 0, qual_en = 0, trig = 0, qual = 0;
   logic [LW-1:0] win_log2 = '0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] rd_addr = '0, ts_idx = '0;
   logic [DW-1:0] rd_data;
   logic [TSW-1:0] ts_data;
   logic armed, done;

   always #(CLK_PERIOD / 2) clk = ~clk;

   qcap_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .TS_W(TSW)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .win_log2(win_log2),
      .qual_en(qual_en), .trig(trig), .qual(qual), .din(din),
      .rd_addr(rd_addr), .rd_data(rd_data), .ts_idx(ts_idx),
      .ts_data(ts_data), .armed(armed), .done(done)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // bench model of the requirements
   int m_st = 0;            // 0 idle, 1 waiting, 2 filling, 3 done
   int m_wp = 0, m_cy = 0, m_wl = 0;
   bit m_qe = 0;
   int m_mem [DEPTH];
   int m_ts [DEPTH];
   bit prev_armed = 0;

   task automatic check(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
      end
   endtask

   task automatic step(input bit a, input int wl, input bit qe, input bit t,
                       input bit q, input int d);
      int wsz;
      bit acc, wr, last;
      arm = a; win_log2 = LW'(wl); qual_en = qe; trig = t; qual = q; din = DW'(d);
      if (a) begin
         m_st = 1; m_wp = 0; m_cy = 0; m_wl = (wl > AW) ? AW : wl; m_qe = qe;
      end else if (m_st == 1 || m_st == 2) begin
         wsz  = DEPTH >> m_wl;
         acc  = (m_st == 1) && t;
         if (acc) m_ts[m_wp / wsz] = m_cy;
         wr   = (m_st == 2 || acc) && (!m_qe || q);
         last = (m_wp % wsz) == wsz - 1;
         if (wr && last) m_st = (m_wp == DEPTH - 1) ? 3 : 1;
         else if (acc)   m_st = 2;
         if (wr) begin
            m_mem[m_wp] = d & 8'hFF;
            m_wp++;
         end
         if (m_cy < 255) m_cy++;
      end
      prev_armed = armed;
      @(posedge clk); #1;
      check("R1", "armed", int'(armed), int'(m_st == 1 || m_st == 2));
      check("R7", "done", int'(done), int'(m_st == 3));
      if (prev_armed && armed) begin
         check("R8", "rd_data while armed", int'(rd_data), 0);
         check("R9", "ts_data while armed", int'(ts_data), 0);
      end
   endtask

   task automatic run_config(input int wl, input bit qe);
      int p, nwin;
      p = wl * 2 + int'(qe);
      step(1, wl, qe, 1, 1, 8'hAA);   // R1: trig during arm has no effect
      for (int c = 0; c < 400 && m_st != 3; c++)
         step(0, wl, qe, ((c + p) % 5) == 2, ((c * 3 + p) % 4) == 1, c * 37 + p * 11 + 5);
      check("R7", "capture completed", int'(done), 1);
      // R7: stimulus after done must not alter the store
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         step(0, wl, qe, 1, 1, 8'hFF);
         check("R3", $sformatf("sample %0d (wl=%0d qe=%0d)", a, wl, qe),
               int'(rd_data), m_mem[a]);
      end
      nwin = 1 << m_wl;
      for (int w = 0; w < nwin; w++) begin
         ts_idx = AW'(w);
         step(0, wl, qe, 1, 0, 0);
         check("R9", $sformatf("stamp %0d (wl=%0d qe=%0d) R6", w, wl, qe),
               int'(ts_data), m_ts[w]);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset armed", int'(armed), 0);
      check("R1", "reset done", int'(done), 0);
      check("R1", "reset rd_data", int'(rd_data), 0);
      check("R1", "reset ts_data", int'(ts_data), 0);
      rst_n = 1'b1;
      // R1: re-arm in the middle of a capture restarts it
      step(1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 1);
      step(0, 0, 0, 0, 0, 2);
      // R2 R4 R5: every window count, qualifier off and on; 6 clamps to 16 windows
      for (int wl = 0; wl <= 4; wl++) begin
         run_config(wl, 0);
         run_config(wl, 1);
      end
      run_config(6, 0);
      run_config(6, 1);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule